// File: doc/BRIEF.md
# Coherent Wide Counter on a Narrow Register Port

This block holds a 32-bit free-running counter and exposes it through a 16-bit register port with a single address bit selecting the lower or the upper half. Because software needs two bus accesses to move a full value, the block keeps those two accesses coherent. It does this in both directions, so a carry between the halves never splits a value.

For a read, software first reads the lower half. That access returns the live lower 16 bits. At the same clock edge the upper 16 bits are frozen into a hold register, and a later read of the upper address returns that frozen copy. For a write, the order is reversed. Software first writes the upper half, which only parks the value in a staging register. The write of the lower half then loads the staged upper half and the new lower half into the counter together at one edge.

The port is a plain strobe, write-enable and address interface. Read data is combinational while the strobe is high.

Top module: `wide_counter_port`

## Requirements
- R1: A synchronous active-high reset clears the counter, the hold register and the staging register to zero.
- R2: While the count enable is high and no lower-half write occurs, the counter advances by exactly one per clock. While the enable is low and no load occurs, it keeps its value.
- R3: Incrementing from 0xFFFF_FFFF gives 0x0000_0000.
- R4: A read strobe with address 0 (lower half) returns counter bits 15:0 as they stand in that cycle.
- R5: At the clock edge that ends an address-0 read, counter bits 31:16 are copied into the hold register.
- R6: A read strobe with address 1 (upper half) returns the hold register, not the live counter bits 31:16.
- R7: A write strobe with address 1 stores the write data in the staging register and leaves the counter unchanged.
- R8: A write strobe with address 0 loads {staging register, write data} into the counter at that edge. This load takes priority over an increment in the same cycle.
- R9: A read with address 1 that has no earlier address-0 read since reset returns zero.
- R10: The read data bus is zero whenever no read strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable |
| bus_sel | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = lower half, 1 = upper half |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |

## Verification
Some rules are local to a single register, and in-line properties check these on every cycle. They cover the increment and hold rules of the counter, wrap to zero, load priority, capture into the hold register, the hold register staying still between captures, staging-register updates, reset clearing, and the idle read bus. The bench scenarios show what only a sequence of accesses can: an upper read returning a stale copy after the counter has moved on, a staged upper half not reaching the counter until the lower write arrives, and a carry across the halves read back as one consistent value.

// File: rtl/wctr_pkg.sv
package wctr_pkg;

    localparam int CNT_W = 32;
    localparam int BUS_W = 16;

    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_sel_e;

    typedef struct packed {
        logic rd_lo;
        logic rd_hi;
        logic wr_lo;
        logic wr_hi;
    } acc_t;

    function automatic acc_t decode_acc(logic sel, logic we, half_sel_e addr);
        acc_t a;
        a.rd_lo = sel && !we && (addr == HALF_LO);
        a.rd_hi = sel && !we && (addr == HALF_HI);
        a.wr_lo = sel &&  we && (addr == HALF_LO);
        a.wr_hi = sel &&  we && (addr == HALF_HI);
        return a;
    endfunction

endpackage

// File: rtl/wctr_core.sv
module wctr_core #(
    parameter int CNT_W = wctr_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (load) cnt <= load_val;
        else if (en)   cnt <= cnt + CNT_W'(1);
    end

    p_inc_r2: assert property (@(posedge clk) disable iff (rst)
        (en && !load) |=> (cnt == $past(cnt) + CNT_W'(1)));

    p_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (!en && !load) |=> $stable(cnt));

    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (en && !load && (cnt == '1)) |=> (cnt == '0));

    p_load_wins_r8: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(load_val)));

    p_reset_cnt_r1: assert property (@(posedge clk)
        rst |=> (cnt == '0));

endmodule

// File: rtl/wctr_shadow.sv
module wctr_shadow #(
    parameter int HI_W = wctr_pkg::CNT_W - wctr_pkg::BUS_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cap,
    input  logic [HI_W-1:0] hi_in,
    input  logic            stg_we,
    input  logic [HI_W-1:0] stg_in,
    output logic [HI_W-1:0] hold,
    output logic [HI_W-1:0] stage
);

    always_ff @(posedge clk) begin
        if (rst)      hold <= '0;
        else if (cap) hold <= hi_in;
    end

    always_ff @(posedge clk) begin
        if (rst)         stage <= '0;
        else if (stg_we) stage <= stg_in;
    end

    p_capture_r5: assert property (@(posedge clk) disable iff (rst)
        cap |=> (hold == $past(hi_in)));

    p_hold_still_r6: assert property (@(posedge clk) disable iff (rst)
        !cap |=> $stable(hold));

    p_stage_wr_r7: assert property (@(posedge clk) disable iff (rst)
        stg_we |=> (stage == $past(stg_in)));

    p_reset_regs_r1: assert property (@(posedge clk)
        rst |=> (hold == '0 && stage == '0));

endmodule

// File: rtl/wctr_rmux.sv
module wctr_rmux #(
    parameter int BUS_W = wctr_pkg::BUS_W,
    parameter int HI_W  = wctr_pkg::CNT_W - wctr_pkg::BUS_W
) (
    input  wctr_pkg::acc_t   acc,
    input  logic [BUS_W-1:0] lo_live,
    input  logic [HI_W-1:0]  hold,
    output logic [BUS_W-1:0] rdata
);

    logic [BUS_W-1:0] hold_ext;

    generate
        if (HI_W >= BUS_W) begin : g_trunc
            assign hold_ext = hold[BUS_W-1:0];
        end else begin : g_pad
            assign hold_ext = {{(BUS_W-HI_W){1'b0}}, hold};
        end
    endgenerate

    always_comb begin
        rdata = '0;
        if (acc.rd_lo)      rdata = lo_live;
        else if (acc.rd_hi) rdata = hold_ext;
    end

endmodule

// File: rtl/wide_counter_port.sv
module wide_counter_port #(
    parameter int CNT_W = wctr_pkg::CNT_W,
    parameter int BUS_W = wctr_pkg::BUS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic             bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata
);
    import wctr_pkg::*;

    localparam int HI_W = CNT_W - BUS_W;

    acc_t             acc;
    logic [CNT_W-1:0] cnt;
    logic [HI_W-1:0]  hold;
    logic [HI_W-1:0]  stage;
    logic [CNT_W-1:0] load_val;

    assign acc      = decode_acc(bus_sel, bus_we, half_sel_e'(bus_addr));
    assign load_val = {stage, bus_wdata};

    wctr_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .en       (cnt_en),
        .load     (acc.wr_lo),
        .load_val (load_val),
        .cnt      (cnt)
    );

    wctr_shadow #(.HI_W(HI_W)) u_shadow (
        .clk    (clk),
        .rst    (rst),
        .cap    (acc.rd_lo),
        .hi_in  (cnt[CNT_W-1:BUS_W]),
        .stg_we (acc.wr_hi),
        .stg_in (HI_W'(bus_wdata)),
        .hold   (hold),
        .stage  (stage)
    );

    wctr_rmux #(.BUS_W(BUS_W), .HI_W(HI_W)) u_rmux (
        .acc     (acc),
        .lo_live (cnt[BUS_W-1:0]),
        .hold    (hold),
        .rdata   (bus_rdata)
    );

    p_idle_bus_r10: assert property (@(posedge clk) disable iff (rst)
        (!bus_sel || bus_we) |-> (bus_rdata == '0));

    p_upper_write_keeps_cnt_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_we && bus_addr && !cnt_en) |=> $stable(cnt));

endmodule

// File: tb/sim_wide_counter_port.sv
`timescale 1ns/1ps
module sim_wide_counter_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cnt_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_addr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    wide_counter_port u0 (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .bus_sel(bus_sel),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic adr, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = adr; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_rd(input logic adr, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = adr;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic load32(input logic [31:0] v);
        bus_wr(1'b1, v[31:16]);
        bus_wr(1'b0, v[15:0]);
    endtask

    task automatic t_reset;
        logic [15:0] d;
        #2 chk("R10 idle bus", bus_rdata, 16'h0000);
        bus_rd(1'b1, d); chk("R9 upper read before any lower read", d, 16'h0000);
        bus_rd(1'b0, d); chk("R1 counter low after reset", d, 16'h0000);
        bus_rd(1'b1, d); chk("R1 counter high after reset", d, 16'h0000);
    endtask

    task automatic t_staged_write;
        logic [15:0] d;
        bus_wr(1'b1, 16'h1234);
        bus_rd(1'b0, d); chk("R7 staged upper not in counter (low)", d, 16'h0000);
        bus_rd(1'b1, d); chk("R7 staged upper not in counter (high)", d, 16'h0000);
        bus_wr(1'b0, 16'hABCD);
        bus_rd(1'b0, d); chk("R8 load low half", d, 16'hABCD);
        bus_rd(1'b1, d); chk("R8 load high half", d, 16'h1234);
    endtask

    task automatic t_carry;
        logic [15:0] d;
        load32(32'h0000_FFFE);
        @(negedge clk); cnt_en = 1'b1;
        repeat (3) @(negedge clk);
        cnt_en = 1'b0;
        bus_rd(1'b0, d); chk("R2 increment low", d, 16'h0001);
        bus_rd(1'b1, d); chk("R2 carry into high", d, 16'h0001);
        bus_rd(1'b0, d); chk("R2 disabled counter holds", d, 16'h0001);
    endtask

    task automatic t_wrap;
        logic [15:0] d;
        load32(32'hFFFF_FFFF);
        @(negedge clk); cnt_en = 1'b1;
        @(negedge clk); cnt_en = 1'b0;
        bus_rd(1'b0, d); chk("R3 wrap low", d, 16'h0000);
        bus_rd(1'b1, d); chk("R3 wrap high", d, 16'h0000);
    endtask

    task automatic t_stale_hold;
        logic [15:0] d;
        load32(32'h0007_0000);
        bus_rd(1'b0, d); chk("R4 low read", d, 16'h0000);
        load32(32'h0099_0000);
        bus_rd(1'b1, d); chk("R6 upper read returns held copy", d, 16'h0007);
        bus_rd(1'b0, d);
        bus_rd(1'b1, d); chk("R5 recapture after new lower read", d, 16'h0099);
    endtask

    task automatic t_live_low;
        logic [15:0] d;
        load32(32'h0000_0010);
        @(negedge clk);
        cnt_en = 1'b1; bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 1'b0;
        #2 chk("R4 live low first cycle", bus_rdata, 16'h0010);
        @(negedge clk);
        #2 chk("R4 live low next cycle", bus_rdata, 16'h0011);
        @(negedge clk);
        bus_sel = 1'b0; cnt_en = 1'b0;
        #2 chk("R10 idle after read", bus_rdata, 16'h0000);
    endtask

    task automatic t_load_priority;
        logic [15:0] d;
        bus_wr(1'b1, 16'h0042);
        @(negedge clk);
        cnt_en = 1'b1; bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 1'b0; bus_wdata = 16'h5000;
        @(negedge clk);
        cnt_en = 1'b0; bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
        bus_rd(1'b0, d); chk("R8 load overrides increment (low)", d, 16'h5000);
        bus_rd(1'b1, d); chk("R8 load overrides increment (high)", d, 16'h0042);
    endtask

    task automatic t_reset_again;
        logic [15:0] d;
        load32(32'h1111_2222);
        bus_rd(1'b0, d);
        bus_wr(1'b1, 16'h3333);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        bus_rd(1'b1, d); chk("R1 hold cleared by reset", d, 16'h0000);
        bus_wr(1'b0, 16'h0001);
        bus_rd(1'b0, d);
        bus_rd(1'b1, d); chk("R1 staging cleared by reset", d, 16'h0000);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_staged_write();
        t_carry();
        t_wrap();
        t_stale_hold();
        t_live_low();
        t_load_priority();
        t_reset_again();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

endmodule